// File: doc/BRIEF.md
# Stereo Auto-Mute Detector

This block sits behind a stereo serial audio receiver and watches the stream of decoded left/right sample pairs. When both channels have carried silent-looking data (every bit 0 or every bit 1) for a long unbroken run of frames, it raises an automatic mute on both channels. The automatic mute drops again as soon as either channel delivers a sample that is not static.

The automatic mute is merged with two active-low manual mute pins, one per channel. The manual pins act combinationally and never disturb the run counter. An active-low enable gates the automatic function; taking it high wipes the run and the automatic mute.

Samples arrive on a valid/ready stream. The block never applies back-pressure: ready is held high, and a frame counts in every cycle where valid is high. Cycles without valid neither extend nor break a run.

Top module: `stereo_automute`

## Requirements
- R1: Out of reset the automatic mute is clear and the run count is zero, so each mute output simply follows its manual mute pin.
- R2: A sample is static when its value is all zeros or all ones (for 24 bits, 24'h000000 or 24'hFFFFFF). A frame is static only when both its left and its right sample are static, in any mix of the two values. Any other value, for example 24'h000001 or 24'h7FFFFF, is non-static.
- R3: With the enable low, the automatic mute is set at the clock edge that accepts the RUN_LEN-th consecutive static frame (8192 by default), and not after RUN_LEN-1 frames.
- R4: An accepted frame with a non-static sample on either channel clears the automatic mute at the edge that accepts it and restarts the run from zero.
- R5: Cycles with smp_valid low neither advance nor break a run.
- R6: The run count saturates at RUN_LEN, so the automatic mute stays set through any number of further static frames.
- R7: While auto_en_n is high, the run count and the automatic mute are cleared at the next clock edge and no static run can set the mute.
- R8: A low level on mute_left_n or mute_right_n sets that channel's mute output in the same cycle, without a clock edge, and leaves the other channel alone.
- R9: The automatic mute acts on both outputs together and its run is unaffected by the manual mute pins; releasing a manual pin does not release an automatic mute.
- R10: smp_ready is always high; the block never stalls the sample stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A left/right sample pair is present |
| smp_ready | output | 1 | Always high; the block accepts every pair |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| auto_en_n | input | 1 | Low enables the automatic mute |
| mute_left_n | input | 1 | Low mutes the left channel at once |
| mute_right_n | input | 1 | Low mutes the right channel at once |
| mute_left | output | 1 | Left channel mute |
| mute_right | output | 1 | Right channel mute |

## Verification
A run counter that drifts by even one frame shows up at the mute outputs only at the end of a run, so the bench brackets the threshold by stopping one frame short and then adding the last frame. A counter that is not cleared by a non-static frame, an idle gap or the enable shows as a mute one run too early after the event, which the bench exposes by counting a fresh full run after each such event. A mute flag stuck or mis-merged with the manual pins shows within the same cycle as the pin change.

// File: rtl/amute_pkg.sv
package amute_pkg;

  // Level class of a single received sample.
  typedef enum logic [1:0] {
    SMP_MIXED = 2'd0,
    SMP_ZEROS = 2'd1,
    SMP_ONES  = 2'd2
  } smp_class_e;

  localparam int NUM_CH = 2;
  localparam int CH_LEFT = 0;
  localparam int CH_RIGHT = 1;

  function automatic logic is_static(input smp_class_e c);
    return c != SMP_MIXED;
  endfunction

endpackage

// File: rtl/amute_level_classify.sv
module amute_level_classify
  import amute_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample,
  output smp_class_e          cls
);

  logic all_ones;
  logic all_zeros;

  assign all_ones  = &sample;
  assign all_zeros = ~|sample;

  always_comb begin
    if (all_zeros)     cls = SMP_ZEROS;
    else if (all_ones) cls = SMP_ONES;
    else               cls = SMP_MIXED;
  end

endmodule

// File: rtl/amute_run_tracker.sv
module amute_run_tracker #(
  parameter int RUN_LEN = 8192,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             frame_stb,
  input  logic             frame_static,
  output logic [CNT_W-1:0] run_cnt,
  output logic             auto_mute
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(RUN_LEN - 1);

  logic at_limit;
  logic reach;

  assign at_limit = (run_cnt == LIMIT);
  assign reach    = (run_cnt >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      auto_mute <= 1'b0;
    end else if (!enable) begin
      run_cnt   <= '0;
      auto_mute <= 1'b0;
    end else if (frame_stb) begin
      if (frame_static) begin
        if (!at_limit) run_cnt <= run_cnt + 1'b1;
        if (reach)     auto_mute <= 1'b1;
      end else begin
        run_cnt   <= '0;
        auto_mute <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/amute_mute_merge.sv
module amute_mute_merge #(
  parameter int NCH = 2
) (
  input  logic           auto_mute,
  input  logic [NCH-1:0] manual_n,
  output logic [NCH-1:0] mute
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign mute[ch] = auto_mute | ~manual_n[ch];
  end

endmodule

// File: rtl/stereo_automute.sv
module stereo_automute
  import amute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                auto_en_n,
  input  logic                mute_left_n,
  input  logic                mute_right_n,
  output logic                mute_left,
  output logic                mute_right
);

  logic [NUM_CH-1:0][SAMPLE_W-1:0] ch_sample;
  smp_class_e                      ch_cls [NUM_CH];
  logic [NUM_CH-1:0]               ch_static;
  logic [NUM_CH-1:0]               manual_n;
  logic [NUM_CH-1:0]               ch_mute;
  logic                            accept;
  logic                            frame_static;
  logic [CNT_W-1:0]                run_cnt;
  logic                            auto_mute_q;

  assign smp_ready = 1'b1;
  assign accept    = smp_valid & smp_ready;

  assign ch_sample[CH_LEFT]  = smp_left;
  assign ch_sample[CH_RIGHT] = smp_right;
  assign manual_n[CH_LEFT]   = mute_left_n;
  assign manual_n[CH_RIGHT]  = mute_right_n;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cls
    amute_level_classify #(.SAMPLE_W(SAMPLE_W)) cls_i (
      .sample (ch_sample[ch]),
      .cls    (ch_cls[ch])
    );
    assign ch_static[ch] = is_static(ch_cls[ch]);
  end

  assign frame_static = &ch_static;

  amute_run_tracker #(.RUN_LEN(RUN_LEN)) run_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (~auto_en_n),
    .frame_stb    (accept),
    .frame_static (frame_static),
    .run_cnt      (run_cnt),
    .auto_mute    (auto_mute_q)
  );

  amute_mute_merge #(.NCH(NUM_CH)) merge_i (
    .auto_mute (auto_mute_q),
    .manual_n  (manual_n),
    .mute      (ch_mute)
  );

  assign mute_left  = ch_mute[CH_LEFT];
  assign mute_right = ch_mute[CH_RIGHT];

endmodule

// File: rtl/stereo_automute_chk.sv
module stereo_automute_chk #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic                smp_ready,
  input logic [SAMPLE_W-1:0] smp_left,
  input logic [SAMPLE_W-1:0] smp_right,
  input logic                auto_en_n,
  input logic                mute_left_n,
  input logic                mute_right_n,
  input logic                mute_left,
  input logic                mute_right,
  input logic [CNT_W-1:0]    run_cnt,
  input logic                auto_mute_q
);

  logic left_flat;
  logic right_flat;
  assign left_flat  = (&smp_left)  | (~|smp_left);
  assign right_flat = (&smp_right) | (~|smp_right);

  // R4
  nonstatic_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !(left_flat && right_flat)) |=> (!auto_mute_q && run_cnt == '0));

  // R7
  enable_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en_n |=> (!auto_mute_q && run_cnt == '0));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(RUN_LEN));

  // R3
  mute_rise_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_mute_q) |-> run_cnt == CNT_W'(RUN_LEN));

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !auto_en_n) |=> ($stable(run_cnt) && $stable(auto_mute_q)));

  // R8
  manual_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_left_n |-> mute_left);

  // R8
  manual_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_right_n |-> mute_right);

  // R9
  outputs_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_left_n && mute_right_n) |-> (mute_left == mute_right));

  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready);

endmodule

bind stereo_automute stereo_automute_chk #(
  .SAMPLE_W(SAMPLE_W),
  .RUN_LEN (RUN_LEN)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .smp_valid    (smp_valid),
  .smp_ready    (smp_ready),
  .smp_left     (smp_left),
  .smp_right    (smp_right),
  .auto_en_n    (auto_en_n),
  .mute_left_n  (mute_left_n),
  .mute_right_n (mute_right_n),
  .mute_left    (mute_left),
  .mute_right   (mute_right),
  .run_cnt      (run_cnt),
  .auto_mute_q  (auto_mute_q)
);

// File: tb/stereo_automute_tb_top.sv
module stereo_automute_tb_top;

  localparam int W = 24;
  localparam int N = 8192;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_valid = 1'b0;
  logic         smp_ready;
  logic [W-1:0] smp_left = '0;
  logic [W-1:0] smp_right = '0;
  logic         auto_en_n = 1'b0;
  logic         mute_left_n = 1'b1;
  logic         mute_right_n = 1'b1;
  logic         mute_left;
  logic         mute_right;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stereo_automute #(.SAMPLE_W(W), .RUN_LEN(N)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .smp_ready    (smp_ready),
    .smp_left     (smp_left),
    .smp_right    (smp_right),
    .auto_en_n    (auto_en_n),
    .mute_left_n  (mute_left_n),
    .mute_right_n (mute_right_n),
    .mute_left    (mute_left),
    .mute_right   (mute_right)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_mutes(input string req, input logic el, input logic er);
    chk({req, " left"}, mute_left, el);
    chk({req, " right"}, mute_right, er);
  endtask

  // Drive n frames, one per cycle, then idle; returns at a negedge after the last capture.
  task automatic send(input int n, input logic [W-1:0] l, input logic [W-1:0] r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_left  = l;
      smp_right = r;
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk_mutes("R1 reset", 1'b0, 1'b0);
    chk("R10 ready", smp_ready, 1'b1);
  endtask

  task automatic t_threshold;
    send(N - 1, '0, '0);
    chk_mutes("R3 one short", 1'b0, 1'b0);
    send(1, '0, '0);
    chk_mutes("R3 at threshold", 1'b1, 1'b1);
    send(2000, '0, '1);
    chk_mutes("R6 saturate", 1'b1, 1'b1);
  endtask

  task automatic t_release;
    send(1, '0, 24'h000001);
    chk_mutes("R4 release right", 1'b0, 1'b0);
    send(N - 1, '1, '1);
    chk_mutes("R4 restart short", 1'b0, 1'b0);
    send(1, '1, '1);
    chk_mutes("R2 all ones mute", 1'b1, 1'b1);
    send(1, 24'h7FFFFF, '0);
    chk_mutes("R2 7FFFFF nonstatic", 1'b0, 1'b0);
  endtask

  task automatic t_gaps;
    send(4000, '1, '0);
    idle(50);
    chk_mutes("R5 mid gap", 1'b0, 1'b0);
    send(N - 4001, '1, '0);
    chk_mutes("R5 gap short", 1'b0, 1'b0);
    send(1, '1, '0);
    chk_mutes("R5 gap kept run", 1'b1, 1'b1);
    idle(20);
    chk_mutes("R5 idle holds mute", 1'b1, 1'b1);
  endtask

  task automatic t_enable;
    @(negedge clk);
    auto_en_n = 1'b1;
    @(negedge clk);
    chk_mutes("R7 disable clears", 1'b0, 1'b0);
    send(N + 100, '0, '0);
    chk_mutes("R7 no mute disabled", 1'b0, 1'b0);
    auto_en_n = 1'b0;
    send(N - 1, '0, '0);
    chk_mutes("R7 counter cleared", 1'b0, 1'b0);
    send(1, '0, '0);
    chk_mutes("R7 re-enabled", 1'b1, 1'b1);
    send(1, '0, 24'h800000);
    chk_mutes("R4 release", 1'b0, 1'b0);
  endtask

  task automatic t_manual;
    mute_left_n = 1'b0;
    #1;
    chk_mutes("R8 left immediate", 1'b1, 1'b0);
    mute_left_n = 1'b1;
    mute_right_n = 1'b0;
    #1;
    chk_mutes("R8 right immediate", 1'b0, 1'b1);
    // Toggle manual pins during a run: run must still complete at N.
    for (int i = 0; i < N - 1; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_left = '0;
      smp_right = '0;
      mute_left_n = i[3];
      mute_right_n = ~i[4];
    end
    @(negedge clk);
    smp_valid = 1'b0;
    mute_left_n = 1'b1;
    mute_right_n = 1'b1;
    #1;
    chk_mutes("R9 short with manual", 1'b0, 1'b0);
    send(1, '0, '0);
    chk_mutes("R9 auto both", 1'b1, 1'b1);
    mute_left_n = 1'b0;
    #1;
    mute_left_n = 1'b1;
    #1;
    chk_mutes("R9 manual release keeps auto", 1'b1, 1'b1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk_mutes("R1 after reset", 1'b0, 1'b0);
    t_threshold;
    t_release;
    t_gaps;
    t_enable;
    t_manual;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule